// File: doc/BRIEF.md
# Linear CCD Drive Timing Generator

This block makes every drive waveform that a two-phase linear CCD image sensor needs, all from one master clock. It produces the transfer gate pulse that ends an integration period and moves charge into the shift registers. It also produces the two complementary shift clocks, and an output reset pulse that marks each pixel period. Every output is a divided-down copy of the master clock, so the phase relations between them are fixed. At a 4 MHz master clock, pixels come out at 1 MHz and the shift clocks run at 0.5 MHz.

Each line opens with a transfer window that is one shift-clock period long. During that window the first shift clock is held high and the second is held low, and the gate pulse sits inside it with two master clocks of margin on each side. After the window the shift clocks toggle normally. The sensor reads out through two shift registers in parallel, so each shift-clock period carries two pixels. For the sampling and conversion stage further down, the block gives a pixel-valid strobe during the settled part of each pixel and a single-cycle line-start marker.

The line length is an input, counted in shift-clock periods. Any value shorter than the readout plus the window is raised to that minimum. A new value takes effect at the next line boundary.

Top module: `ccd_timing_gen`

## Requirements
- R1: `rs_o` is high for exactly one master clock out of every four, on line cycles whose count modulo 4 is 0. It runs on every cycle of the line.
- R2: Outside the transfer window (line cycle 8 onward), `phi1_o` is high on cycles whose count modulo 8 is 4..7 and low on cycles 0..3 modulo 8. `phi2_o` is always its complement.
- R3: `sh_o` is high on line cycles 2, 3, 4 and 5 only, which is 4 master clocks per line.
- R4: On line cycles 0..7, `phi1_o` is high and `phi2_o` is low. The high pulse on `phi1_o` therefore covers `sh_o` with 2 cycles before it and 2 cycles after it.
- R5: A line lasts 8*max(L, M) master clocks. L is `line_len_i` and M = NPIX/2 + 1, where NPIX is effective plus dummy elements; with the default parameters M is 1107.
- R6: `pix_valid_o` is high on slot cycles 2 and 3 of each 4-cycle pixel slot, for NPIX slots starting at line cycle 8, and is low on all other cycles.
- R7: `line_start_o` is high for one cycle per line, at line cycle 10, which is the first valid cycle of the first pixel after the gate pulse.
- R8: `line_len_i` is sampled only when a line wraps. A change in the middle of a line leaves the current line's length unchanged.
- R9: While `rst_n` is low, or on the cycle after `en_i` has been seen low, the outputs are `sh_o`=0, `rs_o`=0, `phi1_o`=1, `phi2_o`=0, `pix_valid_o`=0 and `line_start_o`=0. The first clock edge that sees `en_i` high with reset released produces line cycle 0.
- R10: `phi1_o` and `phi2_o` are never high in the same cycle. Whenever one of them changes, the other changes on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Run enable; low forces the idle levels and restarts the line |
| line_len_i | input | LEN_W | Requested line length in shift-clock periods |
| sh_o | output | 1 | Transfer gate pulse |
| phi1_o | output | 1 | Shift clock, phase 1 |
| phi2_o | output | 1 | Shift clock, phase 2 |
| rs_o | output | 1 | Output reset pulse |
| pix_valid_o | output | 1 | Sample strobe for the conversion stage |
| line_start_o | output | 1 | One-cycle marker at the first pixel of a line |

## Verification
The bench builds the block with 16 effective and 4 dummy elements. The minimum line is then 11 shift-clock periods (88 master clocks), so many whole lines fit into a short run. These small values make the clamp reachable from several requested lengths: 0, a value below the minimum, the exact minimum, and values above it. They also let the bench reach the end of the valid strobe, where the readout stops before a padded line is over. A length change in the middle of a line, a mid-line drop of the enable and a mid-line reset are each followed through the next several line periods.

// File: rtl/ccd_tg_pkg.sv
// Shared constants and types for the CCD drive timing generator.
// Assumes the master clock runs at four times the pixel rate.
package ccd_tg_pkg;

    // Master clocks per pixel slot and per shift-clock period.
    localparam int PIX_CLKS  = 4;
    localparam int PHI_CLKS  = 2 * PIX_CLKS;
    localparam int PHI_LOG   = $clog2(PHI_CLKS);
    localparam int PIX_LOG   = $clog2(PIX_CLKS);

    // Transfer window: the first shift-clock period of each line.
    localparam int SH_LEAD   = 2;
    localparam int SH_WIDTH  = 4;
    localparam int WIN_CLKS  = PHI_CLKS;

    // Slot cycle where the sample strobe opens (after reset settles).
    localparam int SAMPLE_AT = 2;

    // Registered drive levels toward the sensor.
    typedef struct packed {
        logic sh;
        logic phi1;
        logic phi2;
        logic rs;
    } drive_t;

    localparam drive_t DRIVE_IDLE = '{sh: 1'b0, phi1: 1'b1, phi2: 1'b0, rs: 1'b0};

endpackage

// File: rtl/ccd_line_ctr.sv
// Line cycle counter. It counts master clocks inside a line and wraps
// after 8*max(requested, minimum) cycles. The requested length is
// sampled only at a wrap or while idle.
// Assumes rst_n and en_i are synchronous to clk.
module ccd_line_ctr
    import ccd_tg_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int MIN_PHI = 1107,
    localparam int CNT_W  = LEN_W + PHI_LOG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [LEN_W-1:0] line_len_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [LEN_W-1:0] MIN_L    = LEN_W'(MIN_PHI);
    localparam logic [CNT_W-1:0] MIN_LAST = CNT_W'(MIN_PHI * PHI_CLKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_q;
    logic [LEN_W-1:0] len_clamped;
    logic [CNT_W-1:0] last_next;

    // Raise short requests to the minimum and convert to the last cycle index.
    always_comb begin
        len_clamped = (line_len_i < MIN_L) ? MIN_L : line_len_i;
        last_next   = {len_clamped, {PHI_LOG{1'b0}}} - CNT_W'(1);
    end

    // Advance the line count; restart and resample the length at a wrap or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q  <= '0;
            last_q <= last_next;
        end else if (cnt_q == last_q) begin
            cnt_q  <= '0;
            last_q <= last_next;
        end else begin
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt_o = cnt_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last_q); // R5
    AST_LAST_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        last_q >= MIN_LAST); // R5
    AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $past(en_i) && cnt_q != '0) |-> $stable(last_q)); // R8

endmodule

// File: rtl/ccd_phase_gen.sv
// Drive waveform generator. It decodes the line count into the gate
// pulse, the two shift clocks and the reset pulse, with registered
// outputs. Assumes the line count starts at 0 on the first enabled
// edge and is at least one transfer window long.
module ccd_phase_gen
    import ccd_tg_pkg::*;
#(
    parameter int CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] cnt_i,
    output drive_t           drv_o
);

    localparam logic [CNT_W-1:0] WIN_C     = CNT_W'(WIN_CLKS);
    localparam logic [CNT_W-1:0] SH_ON_C   = CNT_W'(SH_LEAD);
    localparam logic [CNT_W-1:0] SH_OFF_C  = CNT_W'(SH_LEAD + SH_WIDTH);
    localparam logic [PHI_LOG-1:0] HALF_C  = PHI_LOG'(PHI_CLKS / 2);

    drive_t drv_next;
    drive_t drv_q;
    logic   in_window;

    // Decode the drive levels for the current line cycle.
    always_comb begin
        in_window     = (cnt_i < WIN_C);
        drv_next.sh   = (cnt_i >= SH_ON_C) && (cnt_i < SH_OFF_C);
        drv_next.phi1 = in_window || (cnt_i[PHI_LOG-1:0] >= HALF_C);
        drv_next.phi2 = !drv_next.phi1;
        drv_next.rs   = (cnt_i[PIX_LOG-1:0] == '0);
    end

    // Register the drive levels; force the idle levels in reset or when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            drv_q <= DRIVE_IDLE;
        end else begin
            drv_q <= drv_next;
        end
    end

    assign drv_o = drv_q;

    AST_SH_IN_PHI1: assert property (@(posedge clk) disable iff (!rst_n)
        drv_q.sh |-> (drv_q.phi1 && !drv_q.phi2)); // R4
    AST_PHI1_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_q.sh) |-> drv_q.phi1); // R4
    AST_PHI_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_q.phi1 && drv_q.phi2)); // R10
    AST_PHI_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(drv_q.phi1) |-> !$stable(drv_q.phi2)); // R10
    AST_RS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        drv_q.rs |=> !drv_q.rs); // R1

endmodule

// File: rtl/ccd_pixel_strobe.sv
// Sample strobe and line marker for the conversion stage. The strobe
// is high in the second half of each pixel slot, for NPIX slots after
// the transfer window. The marker fires on the first strobe cycle of a line.
// Assumes the same line count as the drive generator.
module ccd_pixel_strobe
    import ccd_tg_pkg::*;
#(
    parameter int CNT_W = 19,
    parameter int NPIX  = 2212
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             pix_valid_o,
    output logic             line_start_o
);

    localparam logic [CNT_W-1:0]   WIN_C     = CNT_W'(WIN_CLKS);
    localparam logic [CNT_W-1:0]   PIX_END_C = CNT_W'(WIN_CLKS + NPIX * PIX_CLKS);
    localparam logic [CNT_W-1:0]   START_C   = CNT_W'(WIN_CLKS + SAMPLE_AT);
    localparam logic [PIX_LOG-1:0] SAMPLE_C  = PIX_LOG'(SAMPLE_AT);

    logic valid_next;
    logic start_next;
    logic valid_q;
    logic start_q;

    // Decode whether this cycle is in the readout span and in the sample half.
    always_comb begin
        valid_next = (cnt_i >= WIN_C) && (cnt_i < PIX_END_C)
                     && (cnt_i[PIX_LOG-1:0] >= SAMPLE_C);
        start_next = (cnt_i == START_C);
    end

    // Register the strobes; clear them in reset or when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            valid_q <= 1'b0;
            start_q <= 1'b0;
        end else begin
            valid_q <= valid_next;
            start_q <= start_next;
        end
    end

    assign pix_valid_o  = valid_q;
    assign line_start_o = start_q;

    AST_START_IN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> valid_q); // R7
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q); // R7
    AST_VALID_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_q) |=> valid_q); // R6

endmodule

// File: rtl/ccd_timing_gen.sv
// Top of the CCD drive timing generator. It ties the line counter to
// the drive-waveform decoder and the sample-strobe decoder, so every
// output comes from the same count and has the same latency.
// Assumes NPIX is even, because two shift registers read out in parallel.
module ccd_timing_gen
    import ccd_tg_pkg::*;
#(
    parameter int N_EFFECTIVE = 2160,
    parameter int N_DUMMY     = 52,
    parameter int LEN_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [LEN_W-1:0] line_len_i,
    output logic             sh_o,
    output logic             phi1_o,
    output logic             phi2_o,
    output logic             rs_o,
    output logic             pix_valid_o,
    output logic             line_start_o
);

    localparam int NPIX    = N_EFFECTIVE + N_DUMMY;
    localparam int MIN_PHI = (NPIX + 1) / 2 + WIN_CLKS / PHI_CLKS;
    localparam int CNT_W   = LEN_W + PHI_LOG;

    logic [CNT_W-1:0] line_cnt;
    drive_t           drv;

    ccd_line_ctr #(
        .LEN_W   (LEN_W),
        .MIN_PHI (MIN_PHI)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .line_len_i (line_len_i),
        .cnt_o      (line_cnt)
    );

    ccd_phase_gen #(
        .CNT_W (CNT_W)
    ) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en_i),
        .cnt_i (line_cnt),
        .drv_o (drv)
    );

    ccd_pixel_strobe #(
        .CNT_W (CNT_W),
        .NPIX  (NPIX)
    ) u_strobe (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en_i),
        .cnt_i        (line_cnt),
        .pix_valid_o  (pix_valid_o),
        .line_start_o (line_start_o)
    );

    assign sh_o   = drv.sh;
    assign phi1_o = drv.phi1;
    assign phi2_o = drv.phi2;
    assign rs_o   = drv.rs;

    AST_START_WITH_PHI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        line_start_o |-> (!phi1_o && !sh_o)); // R7

endmodule

// File: tb/ccd_timing_gen_test.sv
// Behavioural reference bench: integer line count, compared every clock.
module ccd_timing_gen_test;

    localparam int NEFF  = 16;
    localparam int NDUM  = 4;
    localparam int NPIX  = NEFF + NDUM;
    localparam int MINL  = NPIX / 2 + 1;
    localparam int LEN_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [LEN_W-1:0] len = 16'd5;
    logic sh, phi1, phi2, rs, pv, ls;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    ccd_timing_gen #(.N_EFFECTIVE(NEFF), .N_DUMMY(NDUM), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .line_len_i(len),
        .sh_o(sh), .phi1_o(phi1), .phi2_o(phi2), .rs_o(rs),
        .pix_valid_o(pv), .line_start_o(ls)
    );

    always #5 clk = ~clk;

    // Reference model state
    int  mcnt = 0, mlast = 0, done_len = 0, exp_gap = 0;
    bit  line_done = 1'b0, gap_chk = 1'b0, m_idle = 1'b1, m_win = 1'b0;
    logic e_sh, e_phi1, e_phi2, e_rs, e_pv, e_ls;
    int  since_ls = 0;

    function automatic int clampv(input int l);
        return (l < MINL) ? MINL : l;
    endfunction

    always @(posedge clk) begin
        if (!rst_n || !en) begin
            {e_sh, e_phi1, e_phi2, e_rs, e_pv, e_ls} = 6'b010000;
            mcnt = 0; mlast = 8 * clampv(int'(len)) - 1;
            line_done = 0; m_idle = 1; m_win = 0;
        end else begin
            m_idle = 0;
            m_win  = (mcnt < 8);
            e_sh   = (mcnt >= 2 && mcnt < 6);
            e_phi1 = m_win || (mcnt % 8 >= 4);
            e_phi2 = !e_phi1;
            e_rs   = (mcnt % 4 == 0);
            e_pv   = (mcnt >= 8) && (mcnt < 8 + 4 * NPIX) && (mcnt % 4 >= 2);
            e_ls   = (mcnt == 10);
            if (e_ls) begin gap_chk = line_done; exp_gap = done_len; end
            if (mcnt == mlast) begin
                done_len = mlast + 1; line_done = 1;
                mcnt = 0; mlast = 8 * clampv(int'(len)) - 1;
            end else mcnt++;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    // Compare every output on each falling edge, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            chk(m_idle ? "R9 sh"   : "R3 sh",       sh,   e_sh);
            chk(m_idle ? "R9 phi1" : (m_win ? "R4 phi1" : "R2 phi1"), phi1, e_phi1);
            chk(m_idle ? "R9 phi2" : (m_win ? "R4 phi2" : "R2 phi2"), phi2, e_phi2);
            chk(m_idle ? "R9 rs"   : "R1 rs",       rs,   e_rs);
            chk(m_idle ? "R9 valid": "R6 valid",    pv,   e_pv);
            chk(m_idle ? "R9 start": "R7 start",    ls,   e_ls);
            chk("R10 phases exclusive", phi1 & phi2, 1'b0);
            since_ls++;
            if (ls) begin
                if (gap_chk) begin
                    checks++;
                    if (since_ls != exp_gap) begin
                        fails++;
                        $display("FAIL R5 R8 line period: actual %0d expected %0d",
                                 since_ls, exp_gap);
                    end
                end
                since_ls = 0;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;          // R9: released but disabled, still idle
        tick(3);
        en = 1'b1;             // R5: request 5, clamped to MINL
        tick(3 * 8 * MINL);
        tick(20);
        len = 16'd14;          // R8: mid-line change, applies next line
        tick(4 * 8 * 14);
        len = 16'd11;          // exact minimum
        tick(3 * 8 * 11);
        len = 16'd0;           // R5: zero clamps
        tick(2 * 8 * MINL + 30);
        len = 16'd12;
        en = 1'b0;             // R9: enable drop mid-line
        tick(5);
        en = 1'b1;
        tick(3 * 8 * 12 + 40);
        rst_n = 1'b0;          // R9: reset mid-line
        tick(2);
        rst_n = 1'b1;
        tick(3 * 8 * 12 + 5);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule